// File: doc/BRIEF.md
# Interleaved Message-Interrupt Collector

This block gathers message-signalled interrupt vectors that arrive as inbound writes to a single doorbell address. It records each one as a pending bit in one of several interrupt groups and drives one interrupt line per group. Consecutive vector numbers are spread across the groups rather than packed into one. Vector v goes to group v mod 8, at bit position v >> 3 within that group. With 8 groups of 4 bits, the block covers 32 vectors.

Software works through a separate register port. Each group has three registers: a pending-status register that is cleared by writing ones, an enable-set register and an enable-clear register. A group's line is a latched level. Once it asserts, it stays asserted until software writes the group's acknowledge code to the end-of-interrupt register. It then drops, and it asserts again one cycle later if an enabled bit is still pending.

Top module: `msi_agg`

## Requirements
- R1: An inbound write to address 0x054 whose data is a vector number v (0 to 31) sets bit v >> 3 of group v mod 8, and no other pending bit.
- R2: An inbound write to any other address, or one whose data has any bit above bit 4 set, changes no pending bit.
- R3: A register read at 0x104 + 0x10·g returns group g's pending bits in data bits [3:0]. A register write at that address clears each pending bit whose data bit is 1, and data bits that are 0 have no effect.
- R4: A write to 0x108 + 0x10·g enables the bits written as 1, and a write to 0x10C + 0x10·g disables them; 0 bits have no effect. A read at either address returns the group's enable mask in bits [3:0]. A pending bit that is disabled does not assert the line.
- R5: When group g's line is low and the group holds a bit that is both pending and enabled, irq_o[g] asserts at the next clock edge.
- R6: A register write to 0x050 with data g + 4 (data values 4 to 11) drops irq_o[g] at that clock edge. Any other data value leaves every line as it was.
- R7: Once asserted, irq_o[g] stays high until the acknowledge for group g, even if its pending bits are cleared or disabled.
- R8: After an acknowledge, irq_o[g] asserts again one cycle later if a pending and enabled bit remains, and stays low otherwise.
- R9: If an inbound vector and a clear of its own pending bit land in the same cycle, the bit stays set.
- R10: Synchronous active-high reset clears all pending bits, all enables, all lines and the read data. Read data appears one cycle after reg_rd is sampled, and any address that maps to no register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| in_wr | input | 1 | Inbound write strobe |
| in_addr | input | 12 | Inbound write byte address |
| in_wdata | input | 32 | Inbound write data (vector number) |
| irq_o | output | 8 | One interrupt line per group |

## Verification
The hardest case to reach from the ports is a collision between the two write paths: an inbound vector and a software clear that land on the same pending bit in the same clock edge. The bench reaches it by driving both strobes in one cycle. In a second collision, the clear hits one bit while a new vector fills its neighbour, so one bit must drop and the other must rise. The latched line is also hard to observe. The bench clears the pending state before it acknowledges, and it sends wrong acknowledge codes while the line is high, so that holding, dropping and re-asserting are each seen on their own. A full sweep over all 32 vector numbers checks the interleaved mapping arithmetically.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

  typedef enum logic [1:0] {
    FN_NONE   = 2'd0,
    FN_STATUS = 2'd1,
    FN_ENSET  = 2'd2,
    FN_ENCLR  = 2'd3
  } reg_fn_e;

endpackage

// File: rtl/msi_agg_regdec.sv
module msi_agg_regdec
  import msi_agg_pkg::*;
#(
  parameter int NG           = 8,
  parameter int NB           = 4,
  parameter int AW           = 12,
  parameter int DW           = 32,
  parameter int STATUS_BASE  = 'h104,
  parameter int GROUP_STRIDE = 'h10,
  parameter int EOI_ADDR     = 'h050,
  parameter int EOI_BIAS     = 4,
  localparam int GW          = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [AW-1:0]          reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [NG-1:0][NB-1:0]  w1c_o,
  output logic [NG-1:0][NB-1:0]  enset_o,
  output logic [NG-1:0][NB-1:0]  enclr_o,
  output logic [NG-1:0]          eoi_o,
  output logic                   rd_hit_o,
  output logic [GW-1:0]          rd_grp_o,
  output reg_fn_e                rd_fn_o
);

  logic [NG-1:0] hit_st, hit_es, hit_ec;
  logic          hit_eoi;

  assign hit_eoi = (reg_addr == AW'(EOI_ADDR));

  for (genvar g = 0; g < NG; g++) begin : g_dec
    assign hit_st[g]  = (reg_addr == AW'(STATUS_BASE + g * GROUP_STRIDE));
    assign hit_es[g]  = (reg_addr == AW'(STATUS_BASE + g * GROUP_STRIDE + 4));
    assign hit_ec[g]  = (reg_addr == AW'(STATUS_BASE + g * GROUP_STRIDE + 8));
    assign w1c_o[g]   = (reg_wr && hit_st[g]) ? reg_wdata[NB-1:0] : '0;
    assign enset_o[g] = (reg_wr && hit_es[g]) ? reg_wdata[NB-1:0] : '0;
    assign enclr_o[g] = (reg_wr && hit_ec[g]) ? reg_wdata[NB-1:0] : '0;
    assign eoi_o[g]   = reg_wr && hit_eoi && (reg_wdata == DW'(g + EOI_BIAS));
  end

  always_comb begin
    rd_hit_o = 1'b0;
    rd_grp_o = '0;
    rd_fn_o  = FN_NONE;
    for (int g = 0; g < NG; g++) begin
      if (reg_rd && hit_st[g]) begin
        rd_hit_o = 1'b1;
        rd_grp_o = GW'(g);
        rd_fn_o  = FN_STATUS;
      end else if (reg_rd && hit_es[g]) begin
        rd_hit_o = 1'b1;
        rd_grp_o = GW'(g);
        rd_fn_o  = FN_ENSET;
      end else if (reg_rd && hit_ec[g]) begin
        rd_hit_o = 1'b1;
        rd_grp_o = GW'(g);
        rd_fn_o  = FN_ENCLR;
      end
    end
  end

endmodule

// File: rtl/msi_agg_doorbell.sv
module msi_agg_doorbell #(
  parameter int NG            = 8,
  parameter int NB            = 4,
  parameter int AW            = 12,
  parameter int DW            = 32,
  parameter int DOORBELL_ADDR = 'h054,
  localparam int GW           = (NG > 1) ? $clog2(NG) : 1,
  localparam int VW           = $clog2(NG * NB),
  localparam int BW           = VW - GW
) (
  input  logic                  in_wr,
  input  logic [AW-1:0]         in_addr,
  input  logic [DW-1:0]         in_wdata,
  output logic [NG-1:0][NB-1:0] set_o
);

  logic          vec_ok;
  logic [GW-1:0] vec_grp;
  logic [BW-1:0] vec_bit;

  // only vectors inside the covered range are accepted
  assign vec_ok  = in_wr && (in_addr == AW'(DOORBELL_ADDR)) && (in_wdata[DW-1:VW] == '0);
  // low bits pick the group, the bits above them pick the position
  assign vec_grp = in_wdata[GW-1:0];
  assign vec_bit = in_wdata[VW-1:GW];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    for (genvar b = 0; b < NB; b++) begin : g_bit
      assign set_o[g][b] = vec_ok && (vec_grp == GW'(g)) && (vec_bit == BW'(b));
    end
  end

endmodule

// File: rtl/msi_agg_group.sv
module msi_agg_group #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] vec_set,
  input  logic [NB-1:0] w1c,
  input  logic [NB-1:0] en_set,
  input  logic [NB-1:0] en_clr,
  input  logic          eoi,
  output logic [NB-1:0] pend_o,
  output logic [NB-1:0] en_o,
  output logic          irq_o
);

  logic [NB-1:0] pend_q, en_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      // an arriving vector wins over a clear of the same bit
      pend_q <= (pend_q & ~w1c) | vec_set;
      en_q   <= (en_q | en_set) & ~en_clr;
      if (irq_q) begin
        if (eoi) irq_q <= 1'b0;
      end else begin
        irq_q <= |(pend_q & en_q);
      end
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/msi_agg.sv
module msi_agg
  import msi_agg_pkg::*;
#(
  parameter int NG            = 8,
  parameter int NB            = 4,
  parameter int AW            = 12,
  parameter int DW            = 32,
  parameter int STATUS_BASE   = 'h104,
  parameter int GROUP_STRIDE  = 'h10,
  parameter int EOI_ADDR      = 'h050,
  parameter int EOI_BIAS      = 4,
  parameter int DOORBELL_ADDR = 'h054
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          in_wr,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  output logic [NG-1:0] irq_o
);

  localparam int GW = (NG > 1) ? $clog2(NG) : 1;

  logic [NG-1:0][NB-1:0] w1c, enset, enclr, db_set, pend_all, en_all;
  logic [NG-1:0]         eoi;
  logic                  rd_hit;
  logic [GW-1:0]         rd_grp;
  reg_fn_e               rd_fn;

  msi_agg_regdec #(
    .NG(NG), .NB(NB), .AW(AW), .DW(DW),
    .STATUS_BASE(STATUS_BASE), .GROUP_STRIDE(GROUP_STRIDE),
    .EOI_ADDR(EOI_ADDR), .EOI_BIAS(EOI_BIAS)
  ) u_dec (
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .w1c_o(w1c), .enset_o(enset), .enclr_o(enclr), .eoi_o(eoi),
    .rd_hit_o(rd_hit), .rd_grp_o(rd_grp), .rd_fn_o(rd_fn)
  );

  msi_agg_doorbell #(
    .NG(NG), .NB(NB), .AW(AW), .DW(DW), .DOORBELL_ADDR(DOORBELL_ADDR)
  ) u_db (
    .in_wr(in_wr), .in_addr(in_addr), .in_wdata(in_wdata), .set_o(db_set)
  );

  for (genvar g = 0; g < NG; g++) begin : g_group
    msi_agg_group #(.NB(NB)) u_grp (
      .clk(clk), .rst(rst),
      .vec_set(db_set[g]), .w1c(w1c[g]),
      .en_set(enset[g]), .en_clr(enclr[g]), .eoi(eoi[g]),
      .pend_o(pend_all[g]), .en_o(en_all[g]), .irq_o(irq_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (!rd_hit)                reg_rdata <= '0;
      else if (rd_fn == FN_STATUS) reg_rdata <= DW'(pend_all[rd_grp]);
      else                         reg_rdata <= DW'(en_all[rd_grp]);
    end
  end

endmodule

// File: rtl/msi_agg_checker.sv
module msi_agg_checker #(
  parameter int NG       = 8,
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int EOI_ADDR = 'h050,
  parameter int EOI_BIAS = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [NG-1:0] irq_o
);

  for (genvar g = 0; g < NG; g++) begin : g_chk
    logic ack;
    assign ack = reg_wr && (reg_addr == AW'(EOI_ADDR)) && (reg_wdata == DW'(g + EOI_BIAS));

    a_r6_ack_drops_line: assert property (@(posedge clk) disable iff (rst)
      (ack && irq_o[g]) |=> !irq_o[g]);

    a_r7_line_held: assert property (@(posedge clk) disable iff (rst)
      (irq_o[g] && !ack) |=> irq_o[g]);
  end

  a_r10_reset_lines: assert property (@(posedge clk)
    rst |=> (irq_o == '0));

  a_r10_reset_rdata: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0));

endmodule

bind msi_agg msi_agg_checker #(
  .NG(NG), .AW(AW), .DW(DW), .EOI_ADDR(EOI_ADDR), .EOI_BIAS(EOI_BIAS)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
);

// File: tb/msi_agg_test.sv
module msi_agg_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, in_wr = 1'b0;
  logic [11:0] reg_addr = '0, in_addr = '0;
  logic [31:0] reg_wdata = '0, in_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msi_agg uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_wr(in_wr), .in_addr(in_addr),
    .in_wdata(in_wdata), .irq_o(irq_o)
  );

  function automatic logic [11:0] st(int g);  return 12'(32'h104 + g * 16); endfunction
  function automatic logic [11:0] es(int g);  return 12'(32'h108 + g * 16); endfunction
  function automatic logic [11:0] ec(int g);  return 12'(32'h10C + g * 16); endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic inb(logic [11:0] a, logic [31:0] d);
    in_wr = 1; in_addr = a; in_wdata = d;
    tick();
    in_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    tick(); tick();
    chk("R10 reset lines", 32'(irq_o), 0);
    chk("R10 reset rdata", reg_rdata, 0);
    rst = 0;
    for (int g = 0; g < 8; g++) begin
      rd(st(g), d); chk("R10 reset pending", d, 0);
      rd(es(g), d); chk("R10 reset enable", d, 0);
    end
    for (int g = 0; g < 8; g++) begin
      wr(es(g), 32'hF);
      rd(ec(g), d); chk("R4 enable readback", d, 32'hF);
    end

    // full vector sweep
    for (int v = 0; v < 32; v++) begin
      int g, b;
      g = v % 8; b = v / 8;
      inb(12'h054, 32'(v));
      rd(st(g), d); chk("R1 R3 pending bit", d, 32'(1 << b));
      rd(st((g + 1) % 8), d); chk("R1 neighbour group", d, 0);
      chk("R5 line rises", 32'(irq_o), 32'(1 << g));
      wr(st(g), 0);
      rd(st(g), d); chk("R3 zero write no effect", d, 32'(1 << b));
      wr(st(g), 32'(1 << b));
      chk("R7 line held after clear", 32'(irq_o), 32'(1 << g));
      wr(12'h050, 32'(g + 4));
      chk("R6 ack drops line", 32'(irq_o), 0);
      tick();
      chk("R8 no reassert when empty", 32'(irq_o), 0);
      rd(st(g), d); chk("R3 cleared", d, 0);
    end

    // wrong acknowledge codes, then reassertion
    inb(12'h054, 32'd5);
    tick();
    chk("R5 line for vector 5", 32'(irq_o), 32'h20);
    wr(12'h050, 32'd5);
    wr(12'h050, 32'd12);
    wr(12'h04C, 32'd9);
    chk("R6 wrong codes ignored", 32'(irq_o), 32'h20);
    wr(12'h050, 32'd9);
    chk("R6 right code drops", 32'(irq_o), 0);
    tick();
    chk("R8 reassert while pending", 32'(irq_o), 32'h20);
    wr(st(5), 32'h1);
    wr(12'h050, 32'd9);
    tick();
    chk("R8 stays low after clear", 32'(irq_o), 0);

    // masking
    wr(ec(2), 32'h2);
    rd(es(2), d); chk("R4 enable clear", d, 32'hD);
    inb(12'h054, 32'd10);
    tick(); tick();
    chk("R4 masked line low", 32'(irq_o), 0);
    rd(st(2), d); chk("R4 masked still pending", d, 32'h2);
    wr(es(2), 0);
    wr(ec(2), 0);
    rd(ec(2), d); chk("R4 zero bits no effect", d, 32'hD);
    wr(es(2), 32'h2);
    chk("R5 line waits one cycle", 32'(irq_o), 0);
    tick();
    chk("R5 line after enable", 32'(irq_o), 32'h04);
    wr(st(2), 32'h2);
    wr(12'h050, 32'd6);
    tick();
    chk("R6 group 2 idle", 32'(irq_o), 0);

    // collision of arrival and clear
    inb(12'h054, 32'd19);
    reg_wr = 1; reg_addr = st(3); reg_wdata = 32'h4;
    in_wr = 1; in_addr = 12'h054; in_wdata = 32'd19;
    tick();
    reg_wr = 0; in_wr = 0;
    rd(st(3), d); chk("R9 same bit stays set", d, 32'h4);
    reg_wr = 1; reg_addr = st(3); reg_wdata = 32'h4;
    in_wr = 1; in_addr = 12'h054; in_wdata = 32'd27;
    tick();
    reg_wr = 0; in_wr = 0;
    rd(st(3), d); chk("R9 other bit clear and set", d, 32'h8);
    wr(st(3), 32'h8);
    wr(12'h050, 32'd7);
    tick();
    chk("R6 group 3 idle", 32'(irq_o), 0);

    // stray inbound writes
    inb(12'h058, 32'd3);
    inb(12'h054, 32'd35);
    inb(12'h054, 32'h100);
    tick(); tick();
    chk("R2 no line", 32'(irq_o), 0);
    rd(st(3), d); chk("R2 group 3 untouched", d, 0);
    rd(st(0), d); chk("R2 group 0 untouched", d, 0);
    rd(12'h100, d); chk("R10 unmapped read", d, 0);
    rd(12'h050, d); chk("R10 ack reg reads zero", d, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule